// File: doc/BRIEF.md
# Keyed Watchdog with Timeout Prescaler

This block is a watchdog for a small processor subsystem. It stays idle after reset until software writes a two-byte key to its service register: 1Eh, then E1h as the very next service write. That key arms the watchdog. The same key, written while the watchdog is armed, clears its count. Once armed, the watchdog can only be stopped by a system reset or by its own timeout. If software fails to service it in time, the block drives a reset pulse of fixed length.

The count advances once per machine cycle, as marked by a one-clock enable from the clock generator. The timeout length comes from a base count width and a prescaler field. With the default base of 14 bits, a prescaler setting S gives a timeout of 2^(14+S)-1 machine cycles. The reset pulse length is counted in oscillator clocks and depends on the clock mode flag at the moment of timeout. When the pulse ends, the block is disarmed with its counter cleared.

Top module: `keyed_wdog`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rst_pulse` and `armed` are 0 and the prescaler field is 0. An armed watchdog is disarmed at once by reset, and the prescaler returns to 0.
- R2: A service write of 1Eh followed by a service write of E1h arms the watchdog. Idle cycles without writes may lie between the two writes. `armed` reads 1 from the cycle after the E1h write.
- R3: A write other than E1h right after 1Eh, a lone E1h, or a repeated 1Eh breaks the key, and that write does not start a new key. A broken key neither arms the watchdog nor clears its count.
- R4: Once armed, no service write or sequence of writes clears `armed`. Only reset or a timeout clears it.
- R5: A complete key written while armed clears the count, so the next timeout comes a full timeout period after the E1h write.
- R6: The count advances only on cycles with `mc_en` high. `rst_pulse` rises after exactly T = 2^(BASE_W+S)-1 enabled cycles following the arming or clearing write. A disarmed watchdog never times out.
- R7: A prescaler write stores `pre_data` as S. With S = 3 or S = 7, the timeout follows the formula of R6.
- R8: The reset pulse lasts exactly PULSE_X2 clocks (96 by default) when `x2_mode` is 1 at timeout, and PULSE_X1 clocks (192 by default) otherwise.
- R9: At timeout `armed` falls in the same cycle that `rst_pulse` rises. Service writes during the pulse are ignored. After the pulse the block stays disarmed, and a new key restarts a full timeout period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | One-clock machine-cycle enable |
| x2_mode | input | 1 | Clock mode flag: 1 selects the short reset pulse |
| svc_we | input | 1 | Service register write strobe |
| svc_data | input | 8 | Service register write data (key bytes) |
| pre_we | input | 1 | Prescaler register write strobe |
| pre_data | input | PRE_W | Prescaler setting S |
| rst_pulse | output | 1 | Reset pulse driven on timeout |
| armed | output | 1 | Watchdog is armed |

## Verification
A service write is sampled at one clock edge and `armed` follows at that same edge. Counting from the E1h edge, `rst_pulse` rises T edges later, with no other register in the path. The pulse then holds for exactly the selected number of clocks. The bench computes each due cycle from the edge index of the write and queues the expected value for that cycle. It samples at the falling edge and checks both the last cycle before each transition and the cycle of the transition. It uses a 4-bit base width so that timeouts stay short.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
   localparam int KWD_KEY_W = 8;
   localparam logic [KWD_KEY_W-1:0] KWD_KEY_OPEN  = 8'h1E;
   localparam logic [KWD_KEY_W-1:0] KWD_KEY_CLOSE = 8'hE1;

   typedef enum logic {
      KS_IDLE = 1'b0,
      KS_HALF = 1'b1
   } key_st_t;
endpackage

// File: rtl/kwd_keyseq.sv
`timescale 1ns/1ps
module kwd_keyseq
   import kwd_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [KWD_KEY_W-1:0] data,
   input  logic                 block,
   output logic                 kick
);
   key_st_t st_q, st_d;

   // Two-step key tracker: any write in the half state ends the attempt.
   always_comb begin
      st_d = st_q;
      kick = 1'b0;
      if (block) begin
         st_d = KS_IDLE;
      end else if (we) begin
         case (st_q)
            KS_IDLE: st_d = (data == KWD_KEY_OPEN) ? KS_HALF : KS_IDLE;
            KS_HALF: begin
               st_d = KS_IDLE;
               kick = (data == KWD_KEY_CLOSE);
            end
            default: st_d = KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/kwd_span.sv
`timescale 1ns/1ps
module kwd_span #(
   parameter int BASE_W = 14,
   parameter int PRE_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick,
   input  logic             mc_en,
   input  logic             pre_we,
   input  logic [PRE_W-1:0] pre_data,
   output logic             armed,
   output logic             fire
);
   localparam int EXT_W = (1 << PRE_W) - 1;
   localparam int CW    = BASE_W + EXT_W;

   logic [PRE_W-1:0] pre_q;
   logic [CW-1:0]    cnt_q;
   logic [CW-1:0]    lim;
   logic             armed_q;

   // Limit mask 2^(BASE_W+S)-1, one comparator per counter bit.
   for (genvar g = 0; g < CW; g++) begin : g_lim
      assign lim[g] = (g < (BASE_W + int'(pre_q)));
   end

   assign fire  = armed_q && mc_en && !kick && (cnt_q >= (lim - CW'(1)));
   assign armed = armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else if (pre_we) pre_q <= pre_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (kick) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (fire) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (armed_q && mc_en) begin
         cnt_q   <= cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/kwd_pulse.sv
`timescale 1ns/1ps
module kwd_pulse #(
   parameter int PULSE_X1 = 192,
   parameter int PULSE_X2 = 96
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic x2_mode,
   output logic active
);
   localparam int PMAX = (PULSE_X1 > PULSE_X2) ? PULSE_X1 : PULSE_X2;
   localparam int PCW  = $clog2(PMAX + 1);

   logic [PCW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         left_q <= '0;
      end else if (fire) begin
         active <= 1'b1;
         left_q <= x2_mode ? PCW'(PULSE_X2 - 1) : PCW'(PULSE_X1 - 1);
      end else if (active) begin
         if (left_q == '0) active <= 1'b0;
         else              left_q <= left_q - PCW'(1);
      end
   end
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog
   import kwd_pkg::*;
#(
   parameter int BASE_W   = 14,
   parameter int PRE_W    = 3,
   parameter int PULSE_X1 = 192,
   parameter int PULSE_X2 = 96
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mc_en,
   input  logic                 x2_mode,
   input  logic                 svc_we,
   input  logic [KWD_KEY_W-1:0] svc_data,
   input  logic                 pre_we,
   input  logic [PRE_W-1:0]     pre_data,
   output logic                 rst_pulse,
   output logic                 armed
);
   if (BASE_W < 2) begin : g_chk_base
      $error("keyed_wdog: BASE_W must be at least 2");
   end
   if (PRE_W < 1 || PRE_W > 4) begin : g_chk_pre
      $error("keyed_wdog: PRE_W must lie in 1..4");
   end
   if (PULSE_X1 < 1 || PULSE_X2 < 1) begin : g_chk_pulse
      $error("keyed_wdog: pulse lengths must be positive");
   end

   logic kick;
   logic fire;

   kwd_keyseq u_key (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (svc_we),
      .data  (svc_data),
      .block (rst_pulse),
      .kick  (kick)
   );

   kwd_span #(.BASE_W(BASE_W), .PRE_W(PRE_W)) u_span (
      .clk      (clk),
      .rst_n    (rst_n),
      .kick     (kick),
      .mc_en    (mc_en),
      .pre_we   (pre_we),
      .pre_data (pre_data),
      .armed    (armed),
      .fire     (fire)
   );

   kwd_pulse #(.PULSE_X1(PULSE_X1), .PULSE_X2(PULSE_X2)) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .x2_mode (x2_mode),
      .active  (rst_pulse)
   );
endmodule

// File: rtl/keyed_wdog_chk.sv
`timescale 1ns/1ps
module keyed_wdog_chk #(
   parameter int PULSE_X1 = 192,
   parameter int PULSE_X2 = 96
) (
   input logic       clk,
   input logic       rst_n,
   input logic       mc_en,
   input logic       x2_mode,
   input logic       svc_we,
   input logic [7:0] svc_data,
   input logic       rst_pulse,
   input logic       armed
);
   localparam int PMAX = (PULSE_X1 > PULSE_X2) ? PULSE_X1 : PULSE_X2;
   localparam int LW   = $clog2(PMAX + 2);

   logic [LW-1:0] ck_len;
   logic          ck_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_len  <= '0;
         ck_mode <= 1'b0;
      end else begin
         ck_len <= rst_pulse ? ck_len + LW'(1) : '0;
         if (!rst_pulse) ck_mode <= x2_mode;
      end
   end

   p_arm_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> ($past(svc_we) && $past(svc_data) == 8'hE1));

   p_no_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(armed) |-> rst_pulse);

   p_timeout_mc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_pulse) |-> ($past(armed) && $past(mc_en)));

   p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_pulse) |-> (ck_len == (ck_mode ? LW'(PULSE_X2) : LW'(PULSE_X1))));

   p_pulse_disarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> !armed);
endmodule

bind keyed_wdog keyed_wdog_chk #(.PULSE_X1(PULSE_X1), .PULSE_X2(PULSE_X2)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mc_en     (mc_en),
   .x2_mode   (x2_mode),
   .svc_we    (svc_we),
   .svc_data  (svc_data),
   .rst_pulse (rst_pulse),
   .armed     (armed)
);

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
   localparam int BW = 4;
   localparam int PW = 3;
   localparam int P1 = 192;
   localparam int P2 = 96;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mc_en = 1'b1;
   logic          x2_mode = 1'b0;
   logic          svc_we = 1'b0;
   logic [7:0]    svc_data = 8'h00;
   logic          pre_we = 1'b0;
   logic [PW-1:0] pre_data = '0;
   logic          rst_pulse;
   logic          armed;

   keyed_wdog #(.BASE_W(BW), .PRE_W(PW), .PULSE_X1(P1), .PULSE_X2(P2)) dut_i (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .x2_mode(x2_mode),
      .svc_we(svc_we), .svc_data(svc_data), .pre_we(pre_we), .pre_data(pre_data),
      .rst_pulse(rst_pulse), .armed(armed)
   );

   always #4 clk = ~clk;

   typedef struct {
      int    cyc;
      int    sig;
      logic  val;
      string tag;
   } exp_t;

   exp_t sbq[$];
   exp_t m_item;
   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 0;
   logic m_act;

   always @(posedge clk) cyc <= cyc + 1;

   // Scoreboard driver side: insert expectation ordered by cycle.
   task automatic push(input int c, input int s, input logic v, input string t);
      exp_t e;
      int   idx;
      e.cyc = c; e.sig = s; e.val = v; e.tag = t;
      idx = sbq.size();
      for (int i = 0; i < sbq.size(); i++) begin
         if (sbq[i].cyc > c) begin idx = i; break; end
      end
      sbq.insert(idx, e);
   endtask

   // Monitor: compare every due expectation at the falling edge.
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
         m_item = sbq.pop_front();
         m_act  = (m_item.sig == 0) ? rst_pulse : armed;
         n_cmp++;
         if (m_item.cyc != cyc || m_act !== m_item.val) begin
            n_bad++;
            $display("FAIL %s: cycle %0d %s actual %b expected %b (due %0d)",
                     m_item.tag, cyc, (m_item.sig == 0) ? "rst_pulse" : "armed",
                     m_act, m_item.val, m_item.cyc);
         end
      end
   end

   task automatic svc(input logic [7:0] d, output int edge_i);
      @(negedge clk); svc_we = 1'b1; svc_data = d;
      @(negedge clk); svc_we = 1'b0; svc_data = 8'h00;
      edge_i = cyc;
   endtask

   task automatic key(output int edge_i);
      int tmp;
      svc(8'h1E, tmp);
      svc(8'hE1, edge_i);
   endtask

   task automatic set_pre(input logic [PW-1:0] s);
      @(negedge clk); pre_we = 1'b1; pre_data = s;
      @(negedge clk); pre_we = 1'b0;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic drain();
      while (sbq.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic int tlim(input int s);
      return (1 << (BW + s)) - 1;
   endfunction

   initial begin
      int a, k, e, L;
      repeat (3) @(negedge clk);
      // R1: state during reset
      push(cyc + 1, 0, 1'b0, "R1");
      push(cyc + 1, 1, 1'b0, "R1");
      wait_to(cyc + 2);
      rst_n = 1'b1;
      push(cyc + 1, 0, 1'b0, "R1");
      push(cyc + 1, 1, 1'b0, "R1");
      // R6: disarmed never times out
      push(cyc + 40, 0, 1'b0, "R6");
      drain();

      // R3: broken keys while disarmed
      svc(8'h1E, e); svc(8'h55, e);
      push(cyc + 1, 1, 1'b0, "R3");
      svc(8'hE1, e);
      push(cyc + 1, 1, 1'b0, "R3");
      svc(8'h1E, e); svc(8'h1E, e); svc(8'hE1, e);
      push(cyc + 1, 1, 1'b0, "R3");
      drain();

      // R2/R6/R8/R9: arm, time out in normal mode
      L = tlim(0);
      key(a);
      push(a + 1, 1, 1'b1, "R2");
      push(a + L - 1, 0, 1'b0, "R6");
      push(a + L, 0, 1'b1, "R6");
      push(a + L, 1, 1'b0, "R9");
      push(a + L + P1 - 1, 0, 1'b1, "R8");
      push(a + L + P1, 0, 1'b0, "R8");
      wait_to(a + L + 5);
      key(e);
      push(e + 1, 1, 1'b0, "R9");
      push(a + L + P1 + 2, 1, 1'b0, "R9");
      drain();

      // R9: re-arm gives full period; R4, R5, R3 while armed; x2 pulse
      x2_mode = 1'b1;
      key(a);
      push(a + 1, 1, 1'b1, "R9");
      wait_to(a + 3);
      svc(8'h00, e); svc(8'h1E, e); svc(8'h55, e);
      push(e + 1, 1, 1'b1, "R4");
      key(k);
      push(a + L, 0, 1'b0, "R5");
      svc(8'h1E, e); svc(8'h1E, e); svc(8'hE1, e);
      push(k + L - 1, 0, 1'b0, "R3");
      push(k + L, 0, 1'b1, "R5");
      push(k + L - 1, 1, 1'b1, "R4");
      push(k + L + P2 - 1, 0, 1'b1, "R8");
      push(k + L + P2, 0, 1'b0, "R8");
      drain();
      x2_mode = 1'b0;

      // R7: prescaler settings 3 and 7
      set_pre(3'd3);
      L = tlim(3);
      key(a);
      push(a + L - 1, 0, 1'b0, "R7");
      push(a + L, 0, 1'b1, "R7");
      drain();
      wait_to(a + L + P1 + 2);
      set_pre(3'd7);
      L = tlim(7);
      key(a);
      push(a + L - 1, 0, 1'b0, "R7");
      push(a + L, 0, 1'b1, "R7");
      drain();
      wait_to(a + L + P1 + 2);

      // R6: no advance without machine-cycle enable
      set_pre(3'd0);
      L = tlim(0);
      mc_en = 1'b0;
      key(a);
      push(a + 40, 0, 1'b0, "R6");
      push(a + 40, 1, 1'b1, "R6");
      wait_to(a + 50);
      mc_en = 1'b1;
      push(a + 50 + L - 1, 0, 1'b0, "R6");
      push(a + 50 + L, 0, 1'b1, "R6");
      drain();
      wait_to(a + 50 + L + P1 + 2);

      // R1: reset while armed, prescaler back to 0
      set_pre(3'd5);
      key(a);
      wait_to(a + 5);
      rst_n = 1'b0;
      push(cyc + 1, 1, 1'b0, "R1");
      push(cyc + 1, 0, 1'b0, "R1");
      wait_to(cyc + 3);
      rst_n = 1'b1;
      key(a);
      push(a + L - 1, 0, 1'b0, "R1");
      push(a + L, 0, 1'b1, "R1");
      drain();

      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule